// File: doc/BRIEF.md
# Two-Wire Bus Activity Monitor

This block listens to a shared two-wire serial bus (one clock line, one data line) without ever driving it. It runs the raw lines through a small synchroniser, then finds the framing events on the synchronised samples. A framing start is the data line falling while the clock line is high; a framing end is the data line rising while the clock line is high. Between those two events the bus counts as occupied, and the block reports this on a busy output.

Inside each framed transfer the block decodes the first byte as a 7-bit target address plus a direction bit. It records whether the ninth clock carried an acknowledge, and it pulses a hit output when the target address equals the address configured for this node. It also gates the local side's wish to transmit. Permission is given only while the bus is idle, so a local transmitter can never cut into a transfer that another node has opened. The system clock is expected to run at least eight times faster than the bus clock.

Top module: `tw_bus_monitor`

## Requirements
- R1: After synchronous reset, busy, grant, addr_hit, cap_rd and cap_ack are 0 and cap_addr is 0.
- R2: A data-line fall while the clock line is high (a start) sets busy within a few system clocks.
- R3: A data-line rise while the clock line is high (a stop) clears busy. A stop seen while idle leaves busy at 0.
- R4: After a start, the first eight clock-line rises sample the address MSB first and then the direction bit, with 1 meaning read. The sequence 0,1,0,0,0,0,0,1 gives cap_addr 0x20 and cap_rd 1.
- R5: On the ninth clock of the address byte, a low data line sets cap_ack to 1 and a high data line sets it to 0. cap_addr and cap_rd are updated on that same clock.
- R6: addr_hit is a single-cycle pulse on the ninth clock of the address byte, raised only when the captured address equals local_addr.
- R7: grant is high only while busy is low and req is high. It stays low from a start until the matching stop.
- R8: A start seen while busy keeps busy high and restarts address capture, so the next byte is decoded as a fresh address.
- R9: After a not-acknowledge on the address byte, later ninth clocks do not change cap_ack until a stop or a new start.
- R10: After an acknowledged address, the ninth clock of every following data byte updates cap_ack by the same rule as R5.
- R11: Data-line changes while the clock line is low are neither a start nor a stop, so busy does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous to clk |
| sda_in | input | 1 | Bus data line, asynchronous to clk |
| req | input | 1 | Local request to begin a transmission |
| local_addr | input | 7 | Address of this node |
| busy | output | 1 | Bus is occupied between a start and a stop |
| grant | output | 1 | Local side may begin transmitting |
| cap_addr | output | 7 | Most recently captured target address |
| cap_rd | output | 1 | Captured direction bit, 1 means read |
| cap_ack | output | 1 | 1 when the last sampled ninth clock was acknowledged |
| addr_hit | output | 1 | One-cycle pulse when the captured address equals local_addr |

## Verification
A bit counter that has slipped by one position shows up at the port as a shifted cap_addr or a swapped cap_rd on the ninth clock of that same byte. It also shows as an acknowledge taken from the wrong clock. A framing state that has stuck is visible as busy or grant failing to follow the next stop or start, within a handful of system clocks. A state that fails to enter the halted mode after a not-acknowledge appears as cap_ack changing on the first data byte that follows.

// File: rtl/tw_mon_pkg.sv
package tw_mon_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_ADDR = 2'd1,
    FR_DATA = 2'd2,
    FR_HALT = 2'd3
  } fr_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_cond_detect.sv
module tw_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise
);
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  // Framing events need the clock line high on both samples
  assign start_det = scl_p & scl_s & sda_p & ~sda_s;
  assign stop_det  = scl_p & scl_s & ~sda_p & sda_s;
  assign scl_rise  = ~scl_p & scl_s;
endmodule

// File: rtl/tw_frame_capture.sv
module tw_frame_capture
  import tw_mon_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] local_addr,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_rd,
  output logic              cap_ack,
  output logic              addr_hit
);
  localparam int CNT_W = $clog2(ADDR_W + 3);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(ADDR_W + 1);

  fr_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W:0]   shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FR_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      cap_addr <= '0;
      cap_rd   <= 1'b0;
      cap_ack  <= 1'b0;
      addr_hit <= 1'b0;
    end else begin
      addr_hit <= 1'b0;
      if (start_det) begin
        state <= FR_ADDR;
        cnt   <= '0;
      end else if (stop_det) begin
        state <= FR_IDLE;
        cnt   <= '0;
      end else if (scl_rise) begin
        case (state)
          FR_ADDR: begin
            if (cnt == ACK_IDX) begin
              cap_addr <= shreg[ADDR_W:1];
              cap_rd   <= shreg[0];
              cap_ack  <= ~sda_s;
              addr_hit <= (shreg[ADDR_W:1] == local_addr);
              cnt      <= '0;
              state    <= sda_s ? FR_HALT : FR_DATA;
            end else begin
              shreg <= {shreg[ADDR_W-1:0], sda_s};
              cnt   <= cnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (cnt == ACK_IDX) begin
              cap_ack <= ~sda_s;
              cnt     <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_bus_monitor.sv
module tw_bus_monitor #(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              req,
  input  logic [ADDR_W-1:0] local_addr,
  output logic              busy,
  output logic              grant,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_rd,
  output logic              cap_ack,
  output logic              addr_hit
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, sync_lines;
  logic scl_s, sda_s;
  logic start_det, stop_det, scl_rise;
  logic busy_d;

  assign raw_lines = {sda_in, scl_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    tw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_lines[i]),
      .q   (sync_lines[i])
    );
  end

  assign scl_s = sync_lines[0];
  assign sda_s = sync_lines[1];

  tw_cond_detect u_det (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise)
  );

  tw_frame_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .scl_rise   (scl_rise),
    .sda_s      (sda_s),
    .local_addr (local_addr),
    .cap_addr   (cap_addr),
    .cap_rd     (cap_rd),
    .cap_ack    (cap_ack),
    .addr_hit   (addr_hit)
  );

  always_comb begin
    busy_d = busy;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      grant <= 1'b0;
    end else begin
      busy  <= busy_d;
      grant <= req & ~busy_d;
    end
  end
endmodule

// File: rtl/tw_bus_monitor_chk.sv
module tw_bus_monitor_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              start_det,
  input logic              stop_det,
  input logic              busy,
  input logic              grant,
  input logic              addr_hit,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [ADDR_W-1:0] local_addr
);
  a_r7_grant_only_idle: assert property (@(posedge clk) disable iff (rst)
    grant |-> !busy);

  a_r6_hit_single_cycle: assert property (@(posedge clk) disable iff (rst)
    addr_hit |=> !addr_hit);

  a_r6_hit_is_local: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> (cap_addr == local_addr));

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_det));

  a_r3_stop_frees_bus: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);

  a_r8_restart_keeps_busy: assert property (@(posedge clk) disable iff (rst)
    (start_det && busy) |=> busy);

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
endmodule

bind tw_bus_monitor tw_bus_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_det  (start_det),
  .stop_det   (stop_det),
  .busy       (busy),
  .grant      (grant),
  .addr_hit   (addr_hit),
  .cap_addr   (cap_addr),
  .local_addr (local_addr)
);

// File: tb/tw_bus_monitor_tb.sv
module tw_bus_monitor_tb;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       scl_in, sda_in, req;
  logic [6:0] local_addr;
  logic       busy, grant, cap_rd, cap_ack, addr_hit;
  logic [6:0] cap_addr;

  int checks = 0;
  int fails  = 0;
  int hits   = 0;

  always #5 clk = ~clk;

  tw_bus_monitor u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .req(req),
    .local_addr(local_addr), .busy(busy), .grant(grant), .cap_addr(cap_addr),
    .cap_rd(cap_rd), .cap_ack(cap_ack), .addr_hit(addr_hit)
  );

  always @(negedge clk) if (!rst && addr_hit) hits++;

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b);
    @(negedge clk); scl_in = 1'b0; wt(H);
    sda_in = b; wt(H);
    scl_in = 1'b1; wt(H);
  endtask

  task automatic do_start();
    @(negedge clk); sda_in = 1'b1; scl_in = 1'b1; wt(H);
    sda_in = 1'b0; wt(H);
  endtask

  task automatic do_restart();
    @(negedge clk); scl_in = 1'b0; wt(H);
    sda_in = 1'b1; wt(H);
    scl_in = 1'b1; wt(H);
    sda_in = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    @(negedge clk); scl_in = 1'b0; wt(H);
    sda_in = 1'b0; wt(H);
    scl_in = 1'b1; wt(H);
    sda_in = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic ninth);
    for (int i = 7; i >= 0; i--) bit_clk(v[i]);
    bit_clk(ninth);
  endtask

  function automatic logic [6:0] exp_addr(input logic [7:0] v);
    return v[7:1];
  endfunction

  function automatic logic exp_ack(input logic ninth);
    return ~ninth;
  endfunction

  // Address byte plus checks of R4, R5, R6
  task automatic addr_phase(input logic [6:0] a, input logic rd, input logic nack);
    int h0;
    logic [7:0] v;
    v  = {a, rd};
    h0 = hits;
    send_byte(v, nack);
    chk("R4 addr", cap_addr, exp_addr(v));
    chk("R4 dir", cap_rd, v[0]);
    chk("R5 ack", cap_ack, exp_ack(nack));
    chk("R6 hit", hits - h0, (a == local_addr) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; scl_in = 1'b1; sda_in = 1'b1; req = 1'b0; local_addr = 7'h20;
    wt(4);
    chk("R1 busy", busy, 0);
    chk("R1 grant", grant, 0);
    chk("R1 addr", cap_addr, 0);
    chk("R1 ack", {cap_rd, cap_ack, addr_hit}, 0);
    @(negedge clk); rst = 1'b0; req = 1'b1; wt(H);
    chk("R7 idle grant", grant, 1);

    // R11: data-line wiggle with clock low while idle
    @(negedge clk); scl_in = 1'b0; wt(H);
    sda_in = 1'b0; wt(H); sda_in = 1'b1; wt(H); sda_in = 1'b0; wt(H);
    scl_in = 1'b1; wt(H);
    chk("R11 idle wiggle", busy, 0);
    // R3: stop while idle
    sda_in = 1'b1; wt(H);
    chk("R3 idle stop", busy, 0);
    chk("R7 idle stop grant", grant, 1);

    // Directed: 0,1,0,0,0,0,0,1 -> 0x20 read, local hit
    do_start();
    chk("R2 busy", busy, 1);
    chk("R7 withheld", grant, 0);
    addr_phase(7'h20, 1'b1, 1'b0);
    send_byte(8'h5A, 1'b1);
    chk("R10 data nack", cap_ack, 0);
    chk("R11 busy mid", busy, 1);
    send_byte(8'hC3, 1'b0);
    chk("R10 data ack", cap_ack, 1);
    // R8: repeated start to a different address
    do_restart();
    chk("R8 busy kept", busy, 1);
    addr_phase(7'h13, 1'b0, 1'b1);
    // R9: after nack, ninth clock low must not set ack
    send_byte(8'h00, 1'b0);
    chk("R9 halted", cap_ack, 0);
    do_stop();
    chk("R3 stop", busy, 0);
    chk("R7 regrant", grant, 1);

    // Random transfers
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a;
      logic rd, nk, n9, rs;
      a  = 7'($urandom);
      rd = 1'($urandom);
      nk = ($urandom % 4) == 0;
      rs = ($urandom % 4) == 0;
      local_addr = ($urandom % 2) ? a : 7'($urandom);
      req = 1'($urandom);
      do_start();
      chk("R2 busy", busy, 1);
      chk("R7 withheld", grant, 0);
      addr_phase(a, rd, nk);
      n9 = 1'($urandom);
      send_byte(8'($urandom), n9);
      if (nk) chk("R9 halted", cap_ack, 0);
      else    chk("R10 data ack", cap_ack, exp_ack(n9));
      if (rs) begin
        do_restart();
        chk("R8 busy kept", busy, 1);
        a = 7'($urandom);
        addr_phase(a, ~rd, 1'b0);
      end
      do_stop();
      chk("R3 stop", busy, 0);
      chk("R7 grant", grant, req);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule